// File: doc/BRIEF.md
# Fast Ethernet MLT-3 Transmit Encoder

This block is the digital transmit path of a 100 Mb/s twisted-pair physical layer. Everything runs on one 125 MHz clock. A free-running divide-by-five timer makes a nibble strobe on every fifth cycle. On each strobe the block takes one 4-bit nibble from the MAC side, or, when no nibble is offered, takes the idle pattern instead. It maps that choice to a 5-bit code group and shifts the group out one bit per cycle.

The serial NRZ bits are first turned into NRZI, where a one toggles the line state. Each NRZI transition then moves a three-level MLT-3 sequencer one step. The result is a 2-bit signed level code that drives an external line driver. The transmit clock never stops. When no frame is sent, the idle code group repeats without a break.

The nibble input is a valid/ready stream. A nibble is consumed only on a cycle where `nib_valid` and `nib_ready` are both high. `nib_ready` is high only on strobe cycles while `frame_en` is high. A source that raises `nib_valid` must keep it high and hold `nib_data` steady until the nibble is taken. Nibble values offered while `nib_ready` is low have no effect.

Top module: `mlt3_tx_encoder`

## Requirements
- R1: While `rst` is high (synchronous, active high), `line_level` is 2'b00 and `nib_ready` is 0. The NRZI state and the MLT-3 position both start from zero.
- R2: Strobe cycles are the 1st clock edge after reset release and every 5th edge after it (edge indices 0, 5, 10, …). `nib_ready` equals `frame_en` on strobe cycles and is 0 on all other cycles.
- R3: A nibble accepted on a strobe is sent as its standard 4B/5B data code group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: On a strobe where no nibble is accepted (`frame_en` low, or `nib_valid` low), the idle code group 11111 is sent.
- R5: Each code group is shifted out most significant bit first, one bit per cycle. The group loaded at edge k provides the serial bits consumed at edges k+1 … k+5.
- R6: The NRZI state toggles on a serial 1 and holds on a serial 0.
- R7: Each NRZI transition moves `line_level` one step through the cycle 0, +1, 0, −1, then back to 0. With no transition the level holds. The encoding is 2'b00 = 0, 2'b01 = +1, 2'b11 = −1. A serial bit consumed at edge j affects `line_level` after edge j+1.
- R8: `nib_data` and `nib_valid` seen on cycles where `nib_ready` is low are not consumed and do not change the line output.
- R9: `line_level` never takes the value 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz line-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_en | input | 1 | Frame transmit enable; when low only idle is sent |
| nib_valid | input | 1 | Nibble offered on `nib_data` |
| nib_data | input | 4 | Data nibble, bit 3 most significant |
| nib_ready | output | 1 | Nibble is taken at this edge if `nib_valid` is high |
| line_level | output | 2 | MLT-3 level code: 00 zero, 01 plus, 11 minus |

## Verification
Two things meet on every strobe cycle. The block decides whether to accept a nibble or insert idle, and at the same edge the last bit of the previous group moves the NRZI and MLT-3 stages. The stimulus changes `frame_en` and `nib_valid` exactly at group boundaries. It also drives unrelated nibble values while `nib_ready` is low, so a mistimed load or a wrong choice between accept and idle corrupts the bit stream. A queue-based scoreboard predicts every expected bit from the stimulus alone and compares the resulting level sequence with `line_level` on every cycle.

// File: rtl/mlt3_tx_pkg.sv
package mlt3_tx_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;
  localparam logic [CG_W-1:0] IDLE_CG = 5'b11111;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } level_e;

  function automatic logic [CG_W-1:0] nib_to_group(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: nib_to_group = 5'b11110;
      4'h1: nib_to_group = 5'b01001;
      4'h2: nib_to_group = 5'b10100;
      4'h3: nib_to_group = 5'b10101;
      4'h4: nib_to_group = 5'b01010;
      4'h5: nib_to_group = 5'b01011;
      4'h6: nib_to_group = 5'b01110;
      4'h7: nib_to_group = 5'b01111;
      4'h8: nib_to_group = 5'b10010;
      4'h9: nib_to_group = 5'b10011;
      4'hA: nib_to_group = 5'b10110;
      4'hB: nib_to_group = 5'b10111;
      4'hC: nib_to_group = 5'b11010;
      4'hD: nib_to_group = 5'b11011;
      4'hE: nib_to_group = 5'b11100;
      default: nib_to_group = 5'b11101;
    endcase
  endfunction
endpackage

// File: rtl/tx_symbol_timer.sv
module tx_symbol_timer #(
  parameter int PERIOD = 5
) (
  input  logic clk,
  input  logic rst,
  output logic load
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign load = (cnt == '0);

  // R2: strobes are isolated, never on two edges in a row
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] group_in,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) sr <= group_in;
    else sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_out = sr[W-1];

  // R5: between loads the next lower bit moves to the serial output
  a_r5_msb_first: assert property (@(posedge clk) disable iff (rst)
    !load |=> bit_out == $past(sr[W-2]));
endmodule

// File: rtl/tx_line_coder.sv
module tx_line_coder
  import mlt3_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_in,
  output logic [1:0] level
);
  logic       nrzi;
  logic       nrzi_prev;
  logic [1:0] step_pos;
  logic       transition;

  always_ff @(posedge clk) begin
    if (rst) begin
      nrzi      <= 1'b0;
      nrzi_prev <= 1'b0;
    end else begin
      nrzi      <= nrzi ^ bit_in;
      nrzi_prev <= nrzi;
    end
  end

  assign transition = nrzi ^ nrzi_prev;

  always_ff @(posedge clk) begin
    if (rst) step_pos <= 2'd0;
    else if (transition) step_pos <= step_pos + 2'd1;
  end

  always_comb begin
    case (step_pos)
      2'd1:    level = LVL_POS;
      2'd3:    level = LVL_NEG;
      default: level = LVL_ZERO;
    endcase
  end

  // R6: a serial one toggles the NRZI state
  a_r6_nrzi_toggle: assert property (@(posedge clk) disable iff (rst)
    bit_in |=> nrzi != $past(nrzi));
  // R6: a serial zero leaves it alone
  a_r6_nrzi_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_in |=> nrzi == $past(nrzi));
  // R7: no transition, no level change
  a_r7_level_hold: assert property (@(posedge clk) disable iff (rst)
    !transition |=> $stable(level));
  // R7: each transition changes the level
  a_r7_level_step: assert property (@(posedge clk) disable iff (rst)
    transition |=> level != $past(level));
  // R9: only three legal codes
  a_r9_level_legal: assert property (@(posedge clk) disable iff (rst)
    level != 2'b10);
endmodule

// File: rtl/mlt3_tx_encoder.sv
module mlt3_tx_encoder
  import mlt3_tx_pkg::*;
#(
  parameter int GROUP_LEN = CG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_en,
  input  logic             nib_valid,
  input  logic [NIB_W-1:0] nib_data,
  output logic             nib_ready,
  output logic [1:0]       line_level
);
  logic            load;
  logic            take;
  logic [CG_W-1:0] group;
  logic            ser_bit;

  tx_symbol_timer #(.PERIOD(GROUP_LEN)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (load)
  );

  assign nib_ready = load & frame_en & ~rst;
  assign take      = nib_ready & nib_valid;
  assign group     = take ? nib_to_group(nib_data) : IDLE_CG;

  tx_serializer #(.W(CG_W)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .group_in (group),
    .bit_out  (ser_bit)
  );

  tx_line_coder u_coder (
    .clk    (clk),
    .rst    (rst),
    .bit_in (ser_bit),
    .level  (line_level)
  );

  // R2: ready only while framing is enabled
  a_r2_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
    nib_ready |-> frame_en);
  // R8: after an accepting strobe, ready stays low on the next edge
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    nib_ready |=> !nib_ready);
endmodule

// File: tb/mlt3_tx_encoder_tb.sv
`timescale 1ns/1ps
module mlt3_tx_encoder_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       frame_en;
  logic       nib_valid;
  logic [3:0] nib_data;
  logic       nib_ready;
  logic [1:0] line_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit   exp_bits[$];
  int   mpos = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [3:0] seq_nib = 4'h0;

  always #2.5 clk = ~clk;

  mlt3_tx_encoder u_dut (
    .clk        (clk),
    .rst        (rst),
    .frame_en   (frame_en),
    .nib_valid  (nib_valid),
    .nib_data   (nib_data),
    .nib_ready  (nib_ready),
    .line_level (line_level)
  );

  function automatic logic [4:0] ref_group(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [1:0] ref_level(input int p);
    case (p % 4)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic push_group(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) exp_bits.push_back(g[i]);
  endtask

  task automatic check(input bit ok, input string tag, input logic [4:0] act,
                       input logic [4:0] exp, input int cyc);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  function automatic string phase_tag(input int n);
    if (n < 40) return "R4 idle";
    if (n < 200) return "R3 data";
    if (n < 400) return "R8 valid gaps";
    return "R4 disabled";
  endfunction

  // driver: chooses inputs for edge n and pushes the predicted code group
  task automatic drive_edge(input int n);
    if (n % 5 == 0) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (n < 40)       begin frame_en = 0; nib_valid = 1; nib_data = lfsr[3:0]; end
      else if (n < 200) begin frame_en = 1; nib_valid = 1; nib_data = seq_nib; end
      else if (n < 400) begin frame_en = 1; nib_valid = lfsr[0]; nib_data = lfsr[7:4]; end
      else              begin frame_en = 0; nib_valid = lfsr[1]; nib_data = lfsr[3:0]; end
      if (frame_en && nib_valid) begin
        push_group(ref_group(nib_data));   // R3
        seq_nib = seq_nib + 4'h1;
      end else begin
        push_group(5'b11111);              // R4
      end
    end else if (!nib_valid) begin
      nib_data = ~nib_data ^ lfsr[3:0];    // R8: unrelated data while not ready
    end
  endtask

  initial begin
    rst = 1; frame_en = 1; nib_valid = 1; nib_data = 4'h3;
    repeat (4) begin
      @(negedge clk);
      check(line_level == 2'b00, "R1 level in reset", {3'b0, line_level}, 5'd0, -1);
      check(nib_ready == 1'b0, "R1 ready in reset", {4'b0, nib_ready}, 5'd0, -1);
    end
    rst = 0;
    for (int n = 0; n < 460; n++) begin
      // monitor: compare the level produced by edges before n
      check(line_level == ref_level(mpos), {phase_tag(n), " R5 R6 R7 level"},
            {3'b0, line_level}, {3'b0, ref_level(mpos)}, n);
      check(line_level != 2'b10, "R9 legal level", {3'b0, line_level}, 5'd0, n);
      drive_edge(n);
      #0.5;
      check(nib_ready == (frame_en && (n % 5 == 0)), "R2 ready strobe",
            {4'b0, nib_ready}, {4'b0, frame_en && (n % 5 == 0)}, n);
      // monitor: bit consumed at edge n-1 reaches the level at edge n
      if (n >= 2) begin
        if (exp_bits.pop_front()) mpos++;
      end
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule